// File: doc/BRIEF.md
# Address Table Slot Search Engine

This block walks an address table from its first entry to its last and decides where a new or updated entry should be written. A search is launched with a one-cycle start pulse that carries a 48-bit MAC address, a 12-bit VLAN id, a flag that says whether the VLAN id applies, and a mode bit that selects an address search or a VLAN search. The block reads one entry per clock through a simple registered read port. It does not hold the table itself and it does not write anything back.

In a single pass the block records three kinds of candidate, each at the lowest index where it occurs: an entry that already matches the key, a free entry, and an entry that may be evicted. When the pass ends it reports the most preferred kind it found, as a two-bit result code with the entry index. A matching entry is preferred over a free one, and a free one over an evictable one. If none of the three exists, the result is table full. The caller takes the index and performs the write.

Top module: `slot_alloc_search`

## Requirements
- R1: In address mode (`vlan_mode_i`=0) an entry matches when its type field, bits 61:60, is 1 (address) or 3 (address with VLAN), its VLAN field, bits 59:48, equals the effective search VLAN, and its bits 47:0 equal `mac_i`.
- R2: In address mode with `vlan_qual_i`=0 the effective search VLAN is 0 and `vid_i` is ignored. With `vlan_qual_i`=1 it is `vid_i`.
- R3: In VLAN mode (`vlan_mode_i`=1) an entry matches only when its type field is 2 and its bits 59:48 equal `vid_i`. `mac_i` and `vlan_qual_i` do not take part.
- R4: When at least one entry matches, the result is 0 (match) with the lowest matching index, even if free or evictable entries exist.
- R5: When no entry matches and at least one entry has type 0, the result is 1 (free) with the lowest such index, even if evictable entries exist.
- R6: When there is neither a match nor a free entry, the result is 2 (evictable) with the lowest index of an entry whose type is 1 or 3, whose bit 40 (multicast) is 0, and whose bits 63:62 hold 1 or 3. The values 0 (persistent) and 2 (vendor prefix) in those bits are never evictable.
- R7: When no candidate of any kind exists, the result is 3 (full) with index 0. After reset the result is 3 with index 0 and `done_o` is 0.
- R8: `done_o` is high for exactly one cycle. It rises on the DEPTH+2-th rising edge after the edge that samples `start_i`. `result_o` and `idx_o` change only on the edge that raises `done_o`.
- R9: A `start_i` pulse seen while a search is in progress (from the edge that accepts a start through the edge that raises `done_o`) is ignored. The search in progress keeps its key, its result and its timing.
- R10: A search asserts `rd_en_o` for DEPTH consecutive cycles, starting in the cycle after the accepting edge, with `rd_idx_o` counting 0, 1, ... DEPTH-1. The entry for a read is expected on `rd_data_i` in the cycle after the read is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a search |
| vlan_mode_i | input | 1 | 0 = address search, 1 = VLAN search |
| vlan_qual_i | input | 1 | 1 = `vid_i` qualifies an address search |
| mac_i | input | 48 | MAC address to search for |
| vid_i | input | 12 | VLAN id to search for |
| rd_en_o | output | 1 | Table read request |
| rd_idx_o | output | IDX_W | Table index being read |
| rd_data_i | input | 64 | Entry returned one cycle after a read |
| done_o | output | 1 | One-cycle end-of-search pulse |
| result_o | output | 2 | 0 match, 1 free, 2 evictable, 3 full |
| idx_o | output | IDX_W | Entry index for the result |

## Verification
Two functions can meet in the same cycle: the acceptance logic for a new start, and a pass still reading and classifying entries. To provoke this, the bench pulses a second start with a different key while reads are in flight, and again on the edge that raises `done_o`. The run passes if the reported result still equals the one computed for the first key, `done_o` rises on the expected edge, and only one done pulse appears. A second overlap is an entry that is both a candidate and appears before a preferred candidate. Tables that place free and evictable entries ahead of a match, across all positions, check that priority decides the result and table order does not.

// File: rtl/slot_alloc_pkg.sv
// Package: entry field positions, type codes and result codes shared by the
// slot search engine and its checker. Assumes a 64-bit entry word.
package slot_alloc_pkg;
    localparam int ENTRY_W  = 64;
    localparam int MAC_W    = 48;
    localparam int VID_W    = 12;
    localparam int NUM_KIND = 3;

    // candidate kinds, in order of preference (lower is preferred)
    localparam int KIND_MATCH = 0;
    localparam int KIND_FREE  = 1;
    localparam int KIND_EVICT = 2;

    // field positions inside an entry
    localparam int TYPE_LO  = 60;
    localparam int VID_LO   = 48;
    localparam int UCT_LO   = 62;
    localparam int MCAST_BIT = 40;

    typedef enum logic [1:0] {
        ET_FREE  = 2'd0,
        ET_ADDR  = 2'd1,
        ET_VLAN  = 2'd2,
        ET_VADDR = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        RES_MATCH = 2'd0,
        RES_FREE  = 2'd1,
        RES_EVICT = 2'd2,
        RES_FULL  = 2'd3
    } res_e;

    // latched search key
    typedef struct packed {
        logic             vlan_mode;
        logic [MAC_W-1:0] mac;
        logic [VID_W-1:0] vid;
    } key_t;
endpackage

// File: rtl/slot_scan_seq.sv
// Scan sequencer: accepts a start when idle, issues DEPTH reads in order,
// delays them by one cycle to line up with the registered read data, and
// signals the end of the pass. Assumes the table has a one-cycle read latency.
module slot_scan_seq #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             rd_en_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             vld_o,
    output logic [IDX_W-1:0] vld_idx_o,
    output logic             fin_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic             busy_q;
    logic             issue_q;
    logic [IDX_W-1:0] cnt_q;
    logic             vld_q;
    logic [IDX_W-1:0] vidx_q;
    logic             fin_q;

    // a start counts only when no pass is running
    always_comb accept_o = start_i && !busy_q;

    // read issue, data alignment and end-of-pass tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            issue_q <= 1'b0;
            cnt_q   <= '0;
            vld_q   <= 1'b0;
            vidx_q  <= '0;
            fin_q   <= 1'b0;
        end else begin
            vld_q  <= issue_q;
            vidx_q <= cnt_q;
            fin_q  <= vld_q && (vidx_q == LAST);
            if (accept_o) begin
                busy_q  <= 1'b1;
                issue_q <= 1'b1;
                cnt_q   <= '0;
            end else if (issue_q) begin
                if (cnt_q == LAST) issue_q <= 1'b0;
                else               cnt_q   <= cnt_q + 1'b1;
            end
            if (fin_q) busy_q <= 1'b0;
        end
    end

    assign busy_o    = busy_q;
    assign rd_en_o   = issue_q;
    assign rd_idx_o  = cnt_q;
    assign vld_o     = vld_q;
    assign vld_idx_o = vidx_q;
    assign fin_o     = fin_q;
endmodule

// File: rtl/slot_entry_class.sv
// Entry classifier: decides, for one table entry and the latched key, whether
// the entry matches, is free, or is evictable. Purely combinational.
module slot_entry_class
    import slot_alloc_pkg::*;
(
    input  logic [ENTRY_W-1:0]  entry_i,
    input  key_t                key_i,
    output logic [NUM_KIND-1:0] hit_o
);
    logic [1:0]       typ;
    logic [1:0]       uct;
    logic [VID_W-1:0] evid;
    logic             is_addr;

    // split fields and evaluate the three candidate rules
    always_comb begin
        typ     = entry_i[TYPE_LO +: 2];
        uct     = entry_i[UCT_LO +: 2];
        evid    = entry_i[VID_LO +: VID_W];
        is_addr = (typ == ET_ADDR) || (typ == ET_VADDR);
        if (key_i.vlan_mode)
            hit_o[KIND_MATCH] = (typ == ET_VLAN) && (evid == key_i.vid);
        else
            hit_o[KIND_MATCH] = is_addr && (evid == key_i.vid)
                                && (entry_i[MAC_W-1:0] == key_i.mac);
        hit_o[KIND_FREE]  = (typ == ET_FREE);
        // low bit of the unicast type set means 1 or 3: not persistent/prefix
        hit_o[KIND_EVICT] = is_addr && !entry_i[MCAST_BIT] && uct[0];
    end
endmodule

// File: rtl/slot_cand_track.sv
// Candidate tracker: remembers the lowest index at which one kind of
// candidate was seen during the current pass. Cleared at each accepted start.
module slot_cand_track #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    // keep only the first hit of the pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            found_o <= 1'b0;
            idx_o   <= '0;
        end else if (clr_i) begin
            found_o <= 1'b0;
        end else if (hit_i && !found_o) begin
            found_o <= 1'b1;
            idx_o   <= idx_i;
        end
    end
endmodule

// File: rtl/slot_alloc_search.sv
// Slot search engine top: latches the key on start, scans the table once,
// tracks match/free/evictable candidates and reports the preferred one.
// Assumes DEPTH >= 2 and a registered table read port.
module slot_alloc_search
    import slot_alloc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               vlan_mode_i,
    input  logic               vlan_qual_i,
    input  logic [MAC_W-1:0]   mac_i,
    input  logic [VID_W-1:0]   vid_i,
    output logic               rd_en_o,
    output logic [IDX_W-1:0]   rd_idx_o,
    input  logic [ENTRY_W-1:0] rd_data_i,
    output logic               done_o,
    output logic [1:0]         result_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic                accept;
    logic                busy;
    logic                vld;
    logic [IDX_W-1:0]    vld_idx;
    logic                fin;
    key_t                key_q;
    logic [NUM_KIND-1:0] hit;
    logic [NUM_KIND-1:0] found;
    logic [IDX_W-1:0]    cidx [NUM_KIND];
    res_e                res_d;
    logic [IDX_W-1:0]    idx_d;

    slot_scan_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .accept_o  (accept),
        .busy_o    (busy),
        .rd_en_o   (rd_en_o),
        .rd_idx_o  (rd_idx_o),
        .vld_o     (vld),
        .vld_idx_o (vld_idx),
        .fin_o     (fin)
    );

    // capture the key; an unqualified address search uses VLAN 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (accept) begin
            key_q.vlan_mode <= vlan_mode_i;
            key_q.mac       <= mac_i;
            key_q.vid       <= (vlan_mode_i || vlan_qual_i) ? vid_i : '0;
        end
    end

    slot_entry_class u_cls (
        .entry_i (rd_data_i),
        .key_i   (key_q),
        .hit_o   (hit)
    );

    for (genvar k = 0; k < NUM_KIND; k++) begin : g_track
        slot_cand_track #(.IDX_W(IDX_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (accept),
            .hit_i   (vld && hit[k]),
            .idx_i   (vld_idx),
            .found_o (found[k]),
            .idx_o   (cidx[k])
        );
    end

    // pick the most preferred kind that was found
    always_comb begin
        res_d = RES_FULL;
        idx_d = '0;
        if (found[KIND_MATCH]) begin
            res_d = RES_MATCH;
            idx_d = cidx[KIND_MATCH];
        end else if (found[KIND_FREE]) begin
            res_d = RES_FREE;
            idx_d = cidx[KIND_FREE];
        end else if (found[KIND_EVICT]) begin
            res_d = RES_EVICT;
            idx_d = cidx[KIND_EVICT];
        end
    end

    // publish the result with a one-cycle done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            result_o <= RES_FULL;
            idx_o    <= '0;
        end else begin
            done_o <= fin;
            if (fin) begin
                result_o <= res_d;
                idx_o    <= idx_d;
            end
        end
    end
endmodule

// File: rtl/slot_alloc_search_chk.sv
// Checker for the slot search engine: port and sequencing properties.
module slot_alloc_search_chk
    import slot_alloc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy,
    input logic             rd_en_o,
    input logic [IDX_W-1:0] rd_idx_o,
    input logic             done_o,
    input logic [1:0]       result_o,
    input logic [IDX_W-1:0] idx_o
);
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(idx_o)));

    a_r7_full_index: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == RES_FULL) |-> (idx_o == '0));

    a_r10_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en_o) |-> (rd_idx_o == '0));

    a_r10_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_idx_o == $past(rd_idx_o) + 1'b1));

    a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (32'(rd_idx_o) < DEPTH));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && rd_en_o && rd_idx_o != '0) |=> (rd_idx_o != '0));

    a_r8_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_en_o);
endmodule

bind slot_alloc_search slot_alloc_search_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy     (busy),
    .rd_en_o  (rd_en_o),
    .rd_idx_o (rd_idx_o),
    .done_o   (done_o),
    .result_o (result_o),
    .idx_o    (idx_o)
);

// File: tb/slot_alloc_search_test.sv
// Bench: models the table with a registered read, fills it with swept and
// pseudo-random patterns, and compares against a priority model.
module slot_alloc_search_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int IW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          vlan_mode_i = 1'b0;
    logic          vlan_qual_i = 1'b0;
    logic [47:0]   mac_i = '0;
    logic [11:0]   vid_i = '0;
    logic          rd_en_o;
    logic [IW-1:0] rd_idx_o;
    logic [63:0]   rd_data_i;
    logic          done_o;
    logic [1:0]    result_o;
    logic [IW-1:0] idx_o;

    logic [63:0] mem [DEPTH];
    int total = 0;
    int bad = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_idx_o];

    slot_alloc_search #(.DEPTH(DEPTH)) uut (.*);

    function automatic logic [63:0] mk(input int typ, input int uct, input bit mc,
                                       input int vid, input logic [47:0] mac);
        logic [63:0] e;
        e = {uct[1:0], typ[1:0], vid[11:0], mac};
        e[40] = mc;
        return e;
    endfunction

    // expected {result, index} from the requirement rules
    function automatic logic [IW+1:0] model(input bit vm, input bit q,
                                           input logic [47:0] mac, input int vid);
        int m = -1, f = -1, a = -1;
        int ev = vm ? vid : (q ? vid : 0);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            int t  = int'(mem[i][61:60]);
            int ut = int'(mem[i][63:62]);
            int v  = int'(mem[i][59:48]);
            bit isa = (t == 1) || (t == 3);
            if (vm ? (t == 2 && v == ev) : (isa && v == ev && mem[i][47:0] == mac)) m = i;
            if (t == 0) f = i;
            if (isa && !mem[i][40] && ut != 0 && ut != 2) a = i;
        end
        if (m >= 0) return {2'd0, IW'(m)};
        if (f >= 0) return {2'd1, IW'(f)};
        if (a >= 0) return {2'd2, IW'(a)};
        return {2'd3, IW'(0)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // run a search; optionally pulse a stray start after 'stray_at' cycles
    task automatic search(input string req, input bit vm, input bit q,
                          input logic [47:0] mac, input int vid, input int stray_at);
        logic [IW+1:0] e;
        int n = 0, rds = 0, nxt = 0, ord_bad = 0, extra = 0;
        e = model(vm, q, mac, vid);
        @(negedge clk);
        vlan_mode_i = vm; vlan_qual_i = q; mac_i = mac; vid_i = 12'(vid);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        vlan_mode_i = ~vm; mac_i = ~mac; vid_i = ~vid_i;
        while (!done_o && n < 100) begin
            if (rd_en_o) begin
                if (int'(rd_idx_o) != nxt) ord_bad++;
                nxt++; rds++;
            end
            if (n == stray_at || (stray_at >= 0 && n == DEPTH + 1)) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        check({req, " latency R8"}, n, DEPTH + 2);
        check({req, " result"}, int'(result_o), int'(e[IW+1:IW]));
        check({req, " index"}, int'(idx_o), int'(e[IW-1:0]));
        check({req, " reads R10"}, rds, DEPTH);
        check({req, " read order R10"}, ord_bad, 0);
        for (int k = 0; k < DEPTH + 4; k++) begin
            @(negedge clk);
            if (done_o) extra++;
            if (result_o != e[IW+1:IW]) extra++;
        end
        check({req, " single done/hold R8 R9"}, extra, 0);
    endtask

    task automatic fill(input logic [63:0] v);
        for (int i = 0; i < DEPTH; i++) mem[i] = v;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] mk_mac;
        mk_mac = 48'h0012_3456_789A;
        fill('0);
        repeat (3) @(negedge clk);
        // reset state R7 R8
        check("reset done R8", int'(done_o), 0);
        check("reset result R7", int'(result_o), 3);
        check("reset index R7", int'(idx_o), 0);
        check("reset read R10", int'(rd_en_o), 0);
        rst_n = 1'b1;

        // empty table: first free R5
        search("empty R5", 0, 0, mk_mac, 0, -1);

        // match at each position, free and evictable ahead of it R1 R4
        for (int p = 0; p < DEPTH; p++) begin
            fill(mk(1, 0, 0, 7, 48'h1111));
            for (int i = 0; i < p; i++) mem[i] = (i % 2) ? mk(0, 0, 0, 0, 0) : mk(3, 1, 0, 7, 48'h22);
            mem[p] = mk(3, 0, 0, 7, mk_mac);
            search("match pos R1 R4", 0, 1, mk_mac, 7, -1);
        end

        // free at each position, evictable ahead R5
        for (int p = 0; p < DEPTH; p++) begin
            fill(mk(1, 0, 0, 0, 48'h5));
            for (int i = 0; i < p; i++) mem[i] = mk(1, 3, 0, 0, 48'h6);
            mem[p] = mk(0, 3, 1, 0, 48'h7);
            search("free pos R5", 0, 0, mk_mac, 0, -1);
        end

        // evictable at each position; non-evictable lookalikes ahead R6
        for (int p = 0; p < DEPTH; p++) begin
            fill(mk(3, 1, 0, 4, 48'h8));
            for (int i = 0; i < p; i++)
                case (i % 4)
                    0: mem[i] = mk(1, 2, 0, 4, 48'h9);
                    1: mem[i] = mk(1, 1, 1, 4, 48'hA);
                    2: mem[i] = mk(2, 3, 0, 4, 48'hB);
                    default: mem[i] = mk(3, 0, 0, 4, 48'hC);
                endcase
            mem[p] = mk((p % 2) ? 1 : 3, (p % 2) ? 3 : 1, 0, 4, 48'hD);
            search("evict pos R6", 0, 0, mk_mac, 0, -1);
        end

        // no candidate of any kind R7
        fill(mk(1, 0, 0, 0, 48'hE));
        search("full persistent R7", 0, 0, mk_mac, 0, -1);
        fill(mk(3, 2, 0, 0, 48'hE));
        search("full prefix R7", 0, 0, mk_mac, 0, -1);
        fill(mk(1, 3, 1, 0, 48'hE));
        search("full multicast R7", 0, 0, mk_mac, 0, -1);

        // unqualified search uses VLAN 0 R2
        fill(mk(1, 0, 0, 0, 48'hF));
        mem[5] = mk(3, 0, 0, 0, mk_mac);
        search("unqualified vid0 R2", 0, 0, mk_mac, 5, -1);
        check("unqualified vid0 R2 idx", int'(idx_o), 5);
        mem[5] = mk(3, 0, 0, 5, mk_mac);
        search("unqualified vid5 R2", 0, 0, mk_mac, 5, -1);
        check("unqualified vid5 R2 code", int'(result_o), 3);
        search("qualified vid5 R2", 0, 1, mk_mac, 5, -1);

        // VLAN mode R3
        for (int p = 1; p < DEPTH; p++) begin
            fill(mk(1, 0, 0, 9, mk_mac));
            mem[p - 1] = mk(3, 0, 0, 9, mk_mac);
            mem[p] = mk(2, 0, 0, 9, 48'h0);
            search("vlan mode R3", 1, 0, mk_mac, 9, -1);
            search("vlan entry in addr mode R3", 0, 1, mk_mac, 9, -1);
        end

        // stray starts during the pass and on the done edge R9
        for (int s = 0; s < DEPTH; s++) begin
            fill(mk(1, 0, 0, 0, 48'h1));
            mem[DEPTH - 1] = mk(1, 0, 0, 3, mk_mac);
            mem[2] = mk(0, 0, 0, 0, 0);
            search("stray start R9", 0, 1, mk_mac, 3, s);
        end

        // pseudo-random tables against the model, all rules
        for (int r = 0; r < 80; r++) begin
            for (int i = 0; i < DEPTH; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                mem[i] = mk(int'(lfsr[1:0]) | (r % 3 == 0 ? 1 : 0), int'(lfsr[3:2]),
                            lfsr[4], int'(lfsr[5]), lfsr[6] ? mk_mac : 48'h3);
            end
            search("random R1 R3 R4 R5 R6 R7", r % 2, lfsr[7], mk_mac, int'(lfsr[8]), -1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule